// File: doc/BRIEF.md
# Triggered Circular Sample Capture Engine

This block records a stream of 64-bit samples into a ring of 8-byte slots. The ring occupies a fixed window of the slot address space, given by a start slot and a slot count. Once enabled, the engine stores samples at a rate set by a 3-bit rate code. It keeps storing while it waits for a trigger event, which is either an edge on a trigger input or a software-style manual strobe. After the trigger it keeps storing for a programmed post-trigger time, then stops.

On completion the engine reports the slot it wrote last and a sticky flag that shows whether the ring wrapped. Software uses these two values to rebuild the sample order. If the ring wrapped, the oldest sample sits one slot after the finish slot and the whole window is valid. If it did not wrap, valid data runs from the start slot up to the finish slot.

The post-trigger time is requested in microseconds. The engine converts it to a 3-bit power-of-two unit and a 7-bit count, and times it with a microsecond tick derived from the core clock.

Top module: `la_capture`

## Requirements
- R1: While reset is held, busy and wrapped read 0, finish_slot equals the start slot, and the status word is the start slot placed in bits 30:16 with every other bit 0.
- R2: When cfg_en is 1 in the idle state, busy reads 1 from the next cycle on. Whenever cfg_en is 0, busy reads 0 in the next cycle; this aborts any capture in progress.
- R3: While busy, a sample is stored once every P cycles. P is 2<<code for rate codes 0 to 6 and 1 for code 7. The first store happens on the clock edge that ends the P-th busy cycle.
- R4: Each store advances the write slot by one. A store into the last slot of the window (start+size-1) sends the next write back to the start slot and sets wrapped. Wrapped stays set until the next arming.
- R5: finish_slot holds the slot of the most recent store. The status word carries wrapped in bit 31, finish_slot in bits 30:16, busy in bit 1, cfg_en in bit 0, and zeros elsewhere.
- R6: When cfg_src is 0, the trigger is a rising edge of trig_in if cfg_edge is 0, and a falling edge if cfg_edge is 1. An edge in the other direction has no effect.
- R7: When cfg_src is 1, only a 0-to-1 change of man_trig triggers, and trig_in is ignored. When cfg_src is 0, man_trig is ignored.
- R8: A requested time of T microseconds (13 bits) is encoded with the smallest exponent u from 0 to 6 for which T>>u is below 128. The effective delay is (T>>u)<<u microseconds, so the low bits are truncated.
- R9: After an accepted trigger, busy stays 1 for exactly D*CLK_PER_US+1 cycles, counting from the cycle after the trigger edge, where D is the effective delay in microseconds.
- R10: An edge seen before arming, a trigger level already present at arming, and any further edge during the post-trigger time all have no effect on the capture length.
- R11: After the post-trigger time ends, the engine stores nothing more. With cfg_en held at 1 it stays done, busy reads 0 and finish_slot is stable; a new capture needs cfg_en to go to 0 and back to 1.
- R12: rd_data returns the sample stored at rd_slot when rd_slot lies inside the window, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Engine enable; 0 aborts and returns to idle |
| cfg_src | input | 1 | Trigger source: 0 trig_in edge, 1 manual strobe |
| cfg_edge | input | 1 | Edge select: 0 rising, 1 falling |
| cfg_rate | input | 3 | Sample rate code |
| cfg_post_us | input | 13 | Requested post-trigger time in microseconds |
| trig_in | input | 1 | Trigger signal from the monitored logic |
| man_trig | input | 1 | Manual trigger bit |
| smp_data | input | DATA_W | Sample word to store |
| rd_slot | input | SLOT_W | Inspection read slot address |
| rd_data | output | DATA_W | Sample stored at rd_slot, 0 outside the window |
| busy | output | 1 | Capture armed or running |
| wrapped | output | 1 | Ring has wrapped at least once since arming |
| finish_slot | output | SLOT_W | Slot of the most recent store |
| status | output | 32 | Packed status word |

## Verification
The assertions assume that trig_in, man_trig and the configuration inputs are synchronous to clk, so the engine sees them without a synchronizer. They also assume the window holds at least two slots. The stimulus changes every input on the falling clock edge. It keeps the rate code, edge, source and requested time fixed from arming until the capture ends or is aborted. A behavioural reference model advances on each rising edge and predicts busy, wrapped, finish_slot and status. The stimulus covers both edge polarities, both trigger sources, several rates including the fastest, a truncated post-trigger time, wrap-around and abort.

// File: rtl/la_cap_pkg.sv
package la_cap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_POST  = 2'd2,
    ST_DONE  = 2'd3
  } cap_state_e;

  // Number of core cycles between sample strobes for a rate code.
  function automatic int unsigned strobe_period(input logic [2:0] code);
    if (code == 3'd7) return 1;
    return 32'd2 << code;
  endfunction

  // Smallest exponent so the requested time fits a 7-bit count.
  function automatic logic [2:0] post_unit(input logic [12:0] req_us);
    logic [2:0] u;
    u = 3'd6;
    for (int k = 6; k >= 0; k--) begin
      if ((req_us >> k) < 13'd128) u = 3'(k);
    end
    return u;
  endfunction

  function automatic logic [6:0] post_count(input logic [12:0] req_us,
                                            input logic [2:0]  u);
    return 7'(req_us >> u);
  endfunction

  // Effective delay in microseconds from the unit/count pair.
  function automatic logic [12:0] post_delay(input logic [2:0] u,
                                             input logic [6:0] cnt);
    return 13'(13'(cnt) << u);
  endfunction

endpackage

// File: rtl/la_edge_det.sv
module la_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic src_manual,
  input  logic edge_fall,
  input  logic trig_in,
  input  logic man_trig,
  output logic evt
);
  logic trig_q;
  logic man_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      man_q  <= 1'b0;
    end else begin
      trig_q <= trig_in;
      man_q  <= man_trig;
    end
  end

  logic sig_rise;
  logic sig_fall;
  logic man_rise;

  assign sig_rise = ~trig_q & trig_in;
  assign sig_fall = trig_q & ~trig_in;
  assign man_rise = ~man_q & man_trig;

  always_comb begin
    if (src_manual)     evt = man_rise;
    else if (edge_fall) evt = sig_fall;
    else                evt = sig_rise;
  end
endmodule

// File: rtl/la_rate_gen.sv
module la_rate_gen
  import la_cap_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] rate,
  output logic       strobe
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic             hit;

  assign last   = CNT_W'(strobe_period(rate) - 1);
  assign hit    = (cnt == last);
  assign strobe = run & hit;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (hit)    cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/la_post_timer.sv
module la_post_timer
  import la_cap_pkg::*;
#(
  parameter int CLK_PER_US = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        run,
  input  logic [12:0] req_us,
  output logic        expired
);
  localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

  logic [2:0]  unit_exp;
  logic [6:0]  unit_cnt;
  logic [12:0] delay_us;
  logic [12:0] left_us;
  logic        us_tick;

  assign unit_exp = post_unit(req_us);
  assign unit_cnt = post_count(req_us, unit_exp);
  assign delay_us = post_delay(unit_exp, unit_cnt);
  assign expired  = (left_us == '0);

  generate
    if (CLK_PER_US > 1) begin : g_prescale
      logic [PRE_W-1:0] pre;
      logic             pre_wrap;
      assign pre_wrap = (pre == PRE_W'(CLK_PER_US - 1));
      assign us_tick  = run & ~expired & pre_wrap;
      always_ff @(posedge clk) begin
        if (!rst_n)                pre <= '0;
        else if (load)             pre <= '0;
        else if (run && !expired)  pre <= pre_wrap ? '0 : pre + 1'b1;
      end
    end else begin : g_direct
      assign us_tick = run & ~expired;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)        left_us <= '0;
    else if (load)     left_us <= delay_us;
    else if (us_tick)  left_us <= left_us - 1'b1;
  end
endmodule

// File: rtl/la_wr_track.sv
module la_wr_track #(
  parameter int SLOT_W     = 15,
  parameter int START_SLOT = 8,
  parameter int SIZE_SLOTS = 24,
  parameter int DATA_W     = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [SLOT_W-1:0] wr_slot,
  output logic [SLOT_W-1:0] finish_slot,
  output logic              wrapped,
  output logic [DATA_W-1:0] rd_data
);
  localparam int IDX_W = (SIZE_SLOTS > 1) ? $clog2(SIZE_SLOTS) : 1;
  localparam logic [SLOT_W-1:0] BASE = SLOT_W'(START_SLOT);

  logic [DATA_W-1:0] mem [SIZE_SLOTS];
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  fin_idx;
  logic              at_last;

  assign at_last     = (idx == IDX_W'(SIZE_SLOTS - 1));
  assign wr_slot     = BASE + SLOT_W'(idx);
  assign finish_slot = BASE + SLOT_W'(fin_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx     <= '0;
      fin_idx <= '0;
      wrapped <= 1'b0;
    end else if (arm) begin
      idx     <= '0;
      fin_idx <= '0;
      wrapped <= 1'b0;
    end else if (wr_en) begin
      fin_idx <= idx;
      if (at_last) begin
        idx     <= '0;
        wrapped <= 1'b1;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wr_data;
  end

  logic [SLOT_W-1:0] rd_off;
  logic              rd_in_win;

  assign rd_off    = rd_slot - BASE;
  assign rd_in_win = (rd_slot >= BASE) && (rd_off < SLOT_W'(SIZE_SLOTS));
  assign rd_data   = rd_in_win ? mem[rd_off[IDX_W-1:0]] : '0;
endmodule

// File: rtl/la_capture.sv
module la_capture
  import la_cap_pkg::*;
#(
  parameter int SLOT_W     = 15,
  parameter int START_SLOT = 8,
  parameter int SIZE_SLOTS = 24,
  parameter int CLK_PER_US = 4,
  parameter int DATA_W     = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_src,
  input  logic              cfg_edge,
  input  logic [2:0]        cfg_rate,
  input  logic [12:0]       cfg_post_us,
  input  logic              trig_in,
  input  logic              man_trig,
  input  logic [DATA_W-1:0] smp_data,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              wrapped,
  output logic [SLOT_W-1:0] finish_slot,
  output logic [31:0]       status
);
  cap_state_e state;
  cap_state_e state_nx;

  logic trig_evt;
  logic strobe;
  logic expired;
  logic arm;
  logic trig_acc;
  logic post_done;
  logic wr_en;
  logic [SLOT_W-1:0] wr_slot;

  assign busy      = (state == ST_ARMED) || (state == ST_POST);
  assign arm       = (state == ST_IDLE) && cfg_en;
  assign trig_acc  = (state == ST_ARMED) && cfg_en && trig_evt;
  assign post_done = (state == ST_POST) && expired;
  assign wr_en     = strobe;

  always_comb begin
    state_nx = state;
    if (!cfg_en) begin
      state_nx = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:  state_nx = ST_ARMED;
        ST_ARMED: if (trig_evt)  state_nx = ST_POST;
        ST_POST:  if (post_done) state_nx = ST_DONE;
        ST_DONE:  state_nx = ST_DONE;
        default:  state_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  la_edge_det u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_manual (cfg_src),
    .edge_fall  (cfg_edge),
    .trig_in    (trig_in),
    .man_trig   (man_trig),
    .evt        (trig_evt)
  );

  la_rate_gen #(.CNT_W(7)) u_rate (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (busy),
    .rate   (cfg_rate),
    .strobe (strobe)
  );

  la_post_timer #(.CLK_PER_US(CLK_PER_US)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (trig_acc),
    .run     (state == ST_POST),
    .req_us  (cfg_post_us),
    .expired (expired)
  );

  la_wr_track #(
    .SLOT_W     (SLOT_W),
    .START_SLOT (START_SLOT),
    .SIZE_SLOTS (SIZE_SLOTS),
    .DATA_W     (DATA_W)
  ) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm         (arm),
    .wr_en       (wr_en),
    .wr_data     (smp_data),
    .rd_slot     (rd_slot),
    .wr_slot     (wr_slot),
    .finish_slot (finish_slot),
    .wrapped     (wrapped),
    .rd_data     (rd_data)
  );

  assign status = {wrapped, 15'(finish_slot), 14'd0, busy, cfg_en};
endmodule

// File: rtl/la_capture_chk.sv
module la_capture_chk
  import la_cap_pkg::*;
#(
  parameter int SLOT_W     = 15,
  parameter int START_SLOT = 8,
  parameter int SIZE_SLOTS = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_en,
  input logic              busy,
  input logic              wrapped,
  input logic [SLOT_W-1:0] finish_slot,
  input logic              wr_en,
  input logic [SLOT_W-1:0] wr_slot,
  input cap_state_e        state
);
  localparam logic [SLOT_W-1:0] FIRST = SLOT_W'(START_SLOT);
  localparam logic [SLOT_W-1:0] LAST  = SLOT_W'(START_SLOT + SIZE_SLOTS - 1);

  assert_finish_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (finish_slot >= FIRST) && (finish_slot <= LAST));

  assert_finish_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (finish_slot == $past(wr_slot)));

  assert_ring_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_slot == LAST) |=> (wr_slot == FIRST) && wrapped);

  assert_wrap_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrapped && state != ST_IDLE) |=> wrapped);

  assert_abort_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !busy);

  assert_store_only_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

  assert_done_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE && cfg_en) |=> (state == ST_DONE) && !busy);

  assert_no_retrigger_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_POST && cfg_en) |=> (state == ST_POST || state == ST_DONE));
endmodule

bind la_capture la_capture_chk #(
  .SLOT_W     (SLOT_W),
  .START_SLOT (START_SLOT),
  .SIZE_SLOTS (SIZE_SLOTS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_en      (cfg_en),
  .busy        (busy),
  .wrapped     (wrapped),
  .finish_slot (finish_slot),
  .wr_en       (wr_en),
  .wr_slot     (wr_slot),
  .state       (state)
);

// File: tb/la_capture_tb.sv
module la_capture_tb;
  localparam int START = 8;
  localparam int SIZE  = 24;
  localparam int CPU   = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_en, cfg_src, cfg_edge;
  logic [2:0]  cfg_rate;
  logic [12:0] cfg_post_us;
  logic        trig_in, man_trig;
  logic [63:0] smp_data;
  logic [14:0] rd_slot;
  logic [63:0] rd_data;
  logic        busy, wrapped;
  logic [14:0] finish_slot;
  logic [31:0] status;

  always #10 clk = ~clk;

  la_capture #(
    .SLOT_W(15), .START_SLOT(START), .SIZE_SLOTS(SIZE), .CLK_PER_US(CPU), .DATA_W(64)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_src(cfg_src), .cfg_edge(cfg_edge),
    .cfg_rate(cfg_rate), .cfg_post_us(cfg_post_us), .trig_in(trig_in), .man_trig(man_trig),
    .smp_data(smp_data), .rd_slot(rd_slot), .rd_data(rd_data), .busy(busy),
    .wrapped(wrapped), .finish_slot(finish_slot), .status(status)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int eff_delay(input int t);
    int u = 0;
    while ((t >> u) >= 128) u++;
    return (t >> u) << u;
  endfunction

  // Behavioural reference: 0 idle, 1 armed, 2 post, 3 done.
  int m_state, m_div, m_left, m_pre, m_wr, m_fin;
  bit m_wrapped, m_pt, m_pm;
  logic [63:0] m_mem [int];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_div = 0; m_left = 0; m_pre = 0;
      m_wr = START; m_fin = START; m_wrapped = 0; m_pt = 0; m_pm = 0;
    end else begin
      int old, per, left_old;
      bit ev, bz, stb;
      old = m_state;
      left_old = m_left;
      if (cfg_src)       ev = man_trig && !m_pm;
      else if (cfg_edge) ev = m_pt && !trig_in;
      else               ev = !m_pt && trig_in;
      bz  = (old == 1) || (old == 2);
      per = (cfg_rate == 3'd7) ? 1 : (2 << cfg_rate);
      stb = bz && (m_div == per - 1);
      if (stb) begin
        m_mem[m_wr] = smp_data;
        m_fin = m_wr;
        if (m_wr == START + SIZE - 1) begin m_wr = START; m_wrapped = 1; end
        else m_wr++;
      end
      m_div = (bz && !stb) ? m_div + 1 : 0;
      if (old == 1 && cfg_en && ev) begin
        m_left = eff_delay(int'(cfg_post_us)); m_pre = 0;
      end else if (old == 2 && m_left != 0) begin
        if (m_pre == CPU - 1) begin m_pre = 0; m_left--; end
        else m_pre++;
      end
      if (!cfg_en) m_state = 0;
      else case (old)
        0: begin m_state = 1; m_wr = START; m_fin = START; m_wrapped = 0; end
        1: if (ev) m_state = 2;
        2: if (left_old == 0) m_state = 3;
        default: ;
      endcase
      m_pt = trig_in;
      m_pm = man_trig;
    end
  end

  // Cycle-by-cycle comparison against the reference.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !finished) begin
      logic mb;
      mb = (m_state == 1) || (m_state == 2);
      chk("R2 busy vs model", busy, mb);
      chk("R4 wrapped vs model", wrapped, m_wrapped);
      chk("R5 finish vs model", finish_slot, m_fin);
      chk("R5 status vs model", status,
          {32'd0, m_wrapped, 15'(m_fin), 14'd0, mb, cfg_en});
    end
  end

  initial begin
    int cyc = 0;
    smp_data = '0;
    forever begin
      @(negedge clk);
      cyc++;
      smp_data = {16'hC0DE, 16'(cyc), ~32'(cyc)};
    end
  end

  task automatic arm(input bit src, input bit edg, input logic [2:0] rate, input int t_us);
    cfg_src = src; cfg_edge = edg; cfg_rate = rate; cfg_post_us = 13'(t_us);
    cfg_en = 1'b1;
    @(negedge clk);
    chk("R2 busy after arming", busy, 1);
  endtask

  task automatic disarm();
    cfg_en = 1'b0;
    @(negedge clk);
    chk("R2 busy after enable cleared", busy, 0);
    @(negedge clk);
  endtask

  task automatic measure(output int n);
    n = 0;
    while (busy === 1'b1 && n < 40000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic done_hold();
    logic [14:0] f0;
    f0 = finish_slot;
    repeat (20) @(negedge clk);
    chk("R11 busy stays low when done", busy, 0);
    chk("R11 finish stable when done", finish_slot, f0);
  endtask

  initial begin
    int n;
    rst_n = 1'b0; cfg_en = 0; cfg_src = 0; cfg_edge = 0; cfg_rate = 0;
    cfg_post_us = 0; trig_in = 0; man_trig = 0; rd_slot = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset wrapped", wrapped, 0);
    chk("R1 reset finish", finish_slot, START);
    chk("R1 reset status", status, 32'(START) << 16);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 rising edge, R9 length, R10 second edge ignored
    arm(0, 0, 3'd0, 3);
    repeat (5) @(negedge clk);
    trig_in = 1'b1;
    @(negedge clk);
    n = 0;
    while (busy === 1'b1 && n < 40000) begin
      n++;
      if (n == 4) trig_in = 1'b0;
      if (n == 6) trig_in = 1'b1;
      @(negedge clk);
    end
    chk("R9 post length 3us", n, 3 * CPU + 1);
    chk("R10 re-edge does not extend", n, 13);
    done_hold();
    disarm();

    // R6 falling edge select; rising edge ignored
    trig_in = 1'b0;
    @(negedge clk);
    arm(0, 1, 3'd1, 0);
    trig_in = 1'b1;
    repeat (10) @(negedge clk);
    chk("R6 rising ignored with falling select", busy, 1);
    trig_in = 1'b0;
    @(negedge clk);
    measure(n);
    chk("R6 falling edge triggers, zero delay", n, 1);
    disarm();

    // R7 manual source, R8 exact unit-1 value
    arm(1, 0, 3'd2, 130);
    trig_in = 1'b0;
    repeat (3) @(negedge clk);
    trig_in = 1'b1;
    repeat (10) @(negedge clk);
    chk("R7 trig_in ignored in manual mode", busy, 1);
    man_trig = 1'b1;
    @(negedge clk);
    measure(n);
    chk("R8 delay 130us", n, 130 * CPU + 1);
    done_hold();
    disarm();
    man_trig = 1'b0;
    trig_in = 1'b0;

    // R7 man_trig ignored on signal source, R8 truncation, R4 wrap, R12 readback
    arm(0, 0, 3'd7, 301);
    man_trig = 1'b1;
    repeat (40) @(negedge clk);
    chk("R7 man_trig ignored in signal mode", busy, 1);
    chk("R4 wrapped after 40 stores", wrapped, 1);
    trig_in = 1'b1;
    @(negedge clk);
    measure(n);
    chk("R8 delay 301us truncated to 300us", n, 300 * CPU + 1);
    for (int s = START; s < START + SIZE; s++) begin
      rd_slot = 15'(s);
      #1;
      chk("R12 readback in window", rd_data, m_mem.exists(s) ? m_mem[s] : 64'hx);
    end
    rd_slot = 15'(START - 1); #1;
    chk("R12 readback below window", rd_data, 0);
    rd_slot = 15'(START + SIZE); #1;
    chk("R12 readback above window", rd_data, 0);
    disarm();
    man_trig = 1'b0;

    // R10 level present at arming, R3 fastest rate
    trig_in = 1'b0;
    @(negedge clk);
    trig_in = 1'b1;
    repeat (2) @(negedge clk);
    arm(0, 0, 3'd7, 5);
    repeat (3) @(negedge clk);
    chk("R3 code 7 stores every cycle", finish_slot, START + 2);
    repeat (20) @(negedge clk);
    chk("R10 pre-arm level is no trigger", busy, 1);
    disarm();

    // R3 code 1 period 4
    arm(0, 0, 3'd1, 0);
    repeat (8) @(negedge clk);
    chk("R3 code 1 two stores in 8 cycles", finish_slot, START + 1);
    chk("R4 wrapped cleared on rearm", wrapped, 0);
    disarm();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule